// File: doc/BRIEF.md
# Word Bit Search Unit

The unit holds one data word and a search mode. It reports where, counting down from the most significant bit, the first bit of interest sits. A write strobe stores the word and the mode together on a clock edge. From the following cycle, the search result is present combinationally on the read port. No further clock cycle is needed.

Three searches are offered:

- The first bit that is set.
- The first bit that is clear.
- The first bit whose value disagrees with the most significant bit. This is useful for normalising signed values or for counting redundant sign bits.

Positions count from 0 at the top bit up to WIDTH-1 at the bottom bit. The value WIDTH means that no bit qualified.

Top module: `bitscan_unit`

## Requirements
- R1: After reset the stored word is all zeros and the mode is first-set. A read therefore returns WIDTH (32).
- R2: Mode 2'b00 returns the position of the highest set bit. Position 0 is bit 31 and position 31 is bit 0.
- R3: Mode 2'b01 returns the position of the highest clear bit, using the same position numbering as R2.
- R4: Mode 2'b10 compares bits 30 down to 0 with bit 31 and returns the position of the first mismatch. It never returns 0. When every bit equals bit 31 it returns 32.
- R5: Mode 2'b11 gives exactly the result of mode 2'b00 for the same word.
- R6: When no bit qualifies, the read returns 32. In first-set mode this happens for an all-zero word. In first-clear mode it happens for an all-ones word.
- R7: A write with wr_en high takes effect at the clock edge. The new result is readable in the cycle immediately after. While wr_en is low, the stored word and mode, and so the result, stay unchanged whatever is on wr_word and wr_mode.
- R8: rd_pos returns the result while rd_en is high and returns 0 while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; stores wr_word and wr_mode |
| wr_word | input | WIDTH (32) | Word to be searched |
| wr_mode | input | 2 | Search mode: 00 set, 01 clear, 10 change, 11 as 00 |
| rd_en | input | 1 | Read strobe |
| rd_pos | output | clog2(WIDTH+1) (6) | Found position, or WIDTH when none |

## Verification
The bench places single bits at both ends of the word and at an interior position. An off-by-one in the position numbering, or a scan that runs from the wrong end, would then return the mirrored or a shifted position.

For change mode, it uses words whose sign run ends right at bit 0, and words that are entirely sign bits. A design that included bit 31 in the comparison would answer 0. A design that lacked the none-found case would answer 31 instead of 32.

It also writes with the strobe low and reads with the read strobe low. A design that latched data without the strobe, or left the read port open, would show a changed or non-zero value.

// File: rtl/bitscan_unit.sv
module bitscan_unit #(
  parameter int WIDTH = 32,
  localparam int POSW = $clog2(WIDTH + 1),
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [1:0]       wr_mode,
  input  logic             rd_en,
  output logic [POSW-1:0]  rd_pos
);

  localparam logic [1:0] MODE_SET    = 2'b00;
  localparam logic [1:0] MODE_CLEAR  = 2'b01;
  localparam logic [1:0] MODE_CHANGE = 2'b10;

  logic [WIDTH-1:0] word_q;
  logic [1:0]       mode_q;
  logic [WIDTH-1:0] target;
  logic [POSW-1:0]  pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= MODE_SET;
    end else if (wr_en) begin
      word_q <= wr_word;
      mode_q <= wr_mode;
    end
  end

  always_comb begin
    case (mode_q)
      MODE_CLEAR:  target = ~word_q;
      MODE_CHANGE: target = {1'b0, word_q[WIDTH-2:0] ^ {(WIDTH-1){word_q[WIDTH-1]}}};
      default:     target = word_q;
    endcase
  end

  always_comb begin
    pos = POSW'(WIDTH);
    for (int i = 0; i < WIDTH; i++)
      if (target[i]) pos = POSW'(WIDTH - 1 - i);
  end

  assign rd_pos = rd_en ? pos : '0;

  logic hit_bit;
  assign hit_bit = word_q[IDXW'(WIDTH - 1) - pos[IDXW-1:0]];

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POSW'(WIDTH));

  p_set_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_CLEAR && mode_q != MODE_CHANGE && pos < POSW'(WIDTH)) |-> hit_bit);

  p_clear_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLEAR && pos < POSW'(WIDTH)) |-> !hit_bit);

  p_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CHANGE) |-> (pos != '0 &&
      (pos == POSW'(WIDTH) || hit_bit != word_q[WIDTH-1])));

  p_none_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SET && pos == POSW'(WIDTH)) |-> (word_q == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pos));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_pos == '0));

endmodule

// File: tb/bitscan_unit_tb.sv
module bitscan_unit_tb_top;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [W-1:0] wr_word = '0;
  logic [1:0]  wr_mode = 2'b00;
  logic        rd_en = 1'b1;
  logic [5:0]  rd_pos;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bitscan_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_mode(wr_mode), .rd_en(rd_en), .rd_pos(rd_pos)
  );

  function automatic int ref_pos(logic [W-1:0] w, logic [1:0] m);
    int p;
    p = 0;
    if (m == 2'b10) begin
      p = 1;
      while (p < W && w[W-1-p] == w[W-1]) p++;
    end else begin
      while (p < W && w[W-1-p] != (m == 2'b01 ? 1'b0 : 1'b1)) p++;
    end
    return p;
  endfunction

  task automatic check(input int exp, input string tag);
    n_cmp++;
    if (int'(rd_pos) != exp) begin
      n_bad++;
      $display("FAIL %s: rd_pos=%0d expected=%0d", tag, rd_pos, exp);
    end
  endtask

  task automatic write_word(input logic [W-1:0] w, input logic [1:0] m);
    @(negedge clk);
    wr_word = w; wr_mode = m; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic try(input logic [W-1:0] w, input logic [1:0] m, input string tag);
    write_word(w, m);
    check(ref_pos(w, m), tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(32, "R1 reset");
  endtask

  task automatic t_first_set;
    try(32'h8000_0000, 2'b00, "R2 msb");
    try(32'h0000_0001, 2'b00, "R2 lsb");
    try(32'h0004_1234, 2'b00, "R2 mid");
    write_word(32'h0000_0100, 2'b00);
    check(23, "R2 bit8");
  endtask

  task automatic t_first_clear;
    try(32'h7FFF_FFFF, 2'b01, "R3 msb");
    try(32'hFFFF_FFFE, 2'b01, "R3 lsb");
    write_word(32'hFFF0_FFFF, 2'b01);
    check(12, "R3 mid");
  endtask

  task automatic t_change;
    write_word(32'h8000_0000, 2'b10);
    check(1, "R4 neg");
    write_word(32'h0000_0001, 2'b10);
    check(31, "R4 lsb");
    write_word(32'hFFFF_FFFE, 2'b10);
    check(31, "R4 neg lsb");
    write_word(32'hFFFF_FFFF, 2'b10);
    check(32, "R4 all ones");
    write_word(32'h0000_0000, 2'b10);
    check(32, "R4 all zeros");
    try(32'hFFE0_1234, 2'b10, "R4 mid");
  endtask

  task automatic t_reserved;
    try(32'h0010_0000, 2'b11, "R5 reserved");
    write_word(32'h0000_0000, 2'b11);
    check(32, "R5 reserved none");
  endtask

  task automatic t_none;
    write_word(32'h0000_0000, 2'b00);
    check(32, "R6 no set");
    write_word(32'hFFFF_FFFF, 2'b01);
    check(32, "R6 no clear");
  endtask

  task automatic t_hold;
    write_word(32'h0000_8000, 2'b00);
    check(16, "R7 write");
    @(negedge clk);
    wr_word = 32'h8000_0000; wr_mode = 2'b01;
    @(negedge clk);
    @(negedge clk);
    check(16, "R7 hold");
  endtask

  task automatic t_read_gate;
    write_word(32'h0000_0002, 2'b00);
    rd_en = 1'b0;
    #1;
    check(0, "R8 gated");
    rd_en = 1'b1;
    #1;
    check(30, "R8 open");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_set();
    t_first_clear();
    t_change();
    t_reserved();
    t_none();
    t_hold();
    t_read_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule